// File: doc/BRIEF.md
# Ring Oscillator Phase Pointer Decoder

This block turns the sampled node levels of an odd-length inverter ring into a phase position and a noise-shaped difference word. On every sample clock edge all node levels are registered. Neighbouring registered nodes are combined by XNOR. In a settled odd ring exactly one pair of neighbours carries equal levels, so the result is a one-hot pointer to the travelling edge. An encoder converts the pointer to a binary position.

A differentiator then subtracts the previous position from the current one, modulo the ring length. With the default length of 15 the modulus is not a power of two, so a borrow is corrected by adding the ring length back. The difference word counts how many stages the edge moved during one sample period. Fed by a voltage- or stress-modulated ring, it forms a first-order delta-sigma stream of the modulating signal.

The parameter RING_LEN must be odd. The position width is the ceiling of log2 of it. The ring itself lies outside the block. Its nodes arrive as a plain vector.

Top module: `ring_phase_decoder`

## Requirements
- R1: While rst_ni is low, pos_o is 0, diff_o is 0 and err_o is 0.
- R2: A node vector sampled on a rising clk_i edge appears on pos_o, diff_o and err_o after the following rising edge. The first edge after reset only captures nodes and leaves the outputs unchanged.
- R3: When exactly one index i has node i equal to node (i+1) mod RING_LEN, pos_o reports i as an unsigned binary number in 0..RING_LEN-1.
- R4: For a valid sample, diff_o equals (new pos_o - previous pos_o) mod RING_LEN, always in 0..RING_LEN-1. An unchanged position gives 0.
- R5: When the new position is below the previous one, diff_o equals new + RING_LEN - previous (with length 15: 13 then 2 gives 4).
- R6: When more than one neighbour pair agrees, err_o is 1, pos_o keeps its previous value and diff_o is 0. No pair agreeing cannot occur in an odd ring.
- R7: After an invalid sample, the next valid sample clears err_o. Its diff_o is measured from the held position.
- R8: An edge advancing one stage per sample gives diff_o = 1 on every sample, including the wrap of pos_o from RING_LEN-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nodes_i | input | RING_LEN | Ring node levels, bit i is node i |
| pos_o | output | POS_W | Pointer position of the last valid sample |
| diff_o | output | POS_W | Position advance modulo RING_LEN |
| err_o | output | 1 | Last sample had more than one agreeing pair |

## Verification
A wrong stored position shows up in diff_o on the very next valid sample, because every difference is taken against that register. A bad borrow correction shows only on samples where the edge wraps past position 0. For that reason the stimulus walks the ring forwards through the wrap, steps backwards, and makes large jumps. A lost hold on an invalid sample shows two edges after that sample, as a changed pos_o while err_o is high, and again one sample later in the diff_o taken from the held value.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int unsigned RING_LEN_DEF = 15;

  function automatic int unsigned pos_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/node_sampler.sv
module node_sampler #(
  parameter int unsigned N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] nodes_i,
  output logic [N-1:0] samp_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      samp_o <= nodes_i;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/pointer_gen.sv
module pointer_gen #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0] samp_i,
  output logic [N-1:0] ptr_o
);
  for (genvar i = 0; i < N; i++) begin : g_pair
    localparam int unsigned NXT = (i + 1) % N;
    assign ptr_o[i] = ~(samp_i[i] ^ samp_i[NXT]);
  end
endmodule

// File: rtl/pointer_encoder.sv
module pointer_encoder #(
  parameter int unsigned N = 15,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] ptr_i,
  output logic [W-1:0] idx_o,
  output logic         single_o
);
  localparam int unsigned CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  // lowest active index wins: scan downwards, last hit sticks
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ptr_i[i]) idx_o = W'(i);
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(ptr_i[i]);
  end

  assign single_o = (cnt == CW'(1));
endmodule

// File: rtl/mod_diff.sv
module mod_diff #(
  parameter int unsigned N = 15,
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         single_i,
  input  logic [W-1:0] idx_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] diff_o,
  output logic         err_o
);
  localparam logic [W-1:0] MODV = W'(N);

  logic [W:0]   raw;
  logic [W-1:0] wrapped;

  assign raw     = {1'b0, idx_i} - {1'b0, pos_o};
  // borrow: bring the 2^W wrap back to a modulo-N wrap
  assign wrapped = raw[W] ? (raw[W-1:0] + MODV) : raw[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      diff_o <= '0;
      err_o  <= 1'b0;
    end else if (en_i) begin
      if (single_i) begin
        pos_o  <= idx_i;
        diff_o <= wrapped;
        err_o  <= 1'b0;
      end else begin
        diff_o <= '0;
        err_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_phase_decoder.sv
module ring_phase_decoder
  import ring_ptr_pkg::*;
#(
  parameter int unsigned RING_LEN = RING_LEN_DEF,
  parameter int unsigned POS_W    = pos_width(RING_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RING_LEN-1:0] nodes_i,
  output logic [POS_W-1:0]    pos_o,
  output logic [POS_W-1:0]    diff_o,
  output logic                err_o
);
  if ((RING_LEN % 2) == 0 || RING_LEN < 3) begin : g_bad_len
    $error("RING_LEN must be odd and at least 3");
  end

  logic [RING_LEN-1:0] samp;
  logic                samp_vld;
  logic [RING_LEN-1:0] ptr;
  logic [POS_W-1:0]    idx;
  logic                single;

  node_sampler #(.N(RING_LEN)) u_samp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nodes_i(nodes_i),
    .samp_o (samp),
    .vld_o  (samp_vld)
  );

  pointer_gen #(.N(RING_LEN)) u_ptr (
    .samp_i(samp),
    .ptr_o (ptr)
  );

  pointer_encoder #(.N(RING_LEN), .W(POS_W)) u_enc (
    .ptr_i   (ptr),
    .idx_o   (idx),
    .single_o(single)
  );

  mod_diff #(.N(RING_LEN), .W(POS_W)) u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (samp_vld),
    .single_i(single),
    .idx_i   (idx),
    .pos_o   (pos_o),
    .diff_o  (diff_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/ring_phase_decoder_chk.sv
module ring_phase_decoder_chk #(
  parameter int unsigned RING_LEN = 15,
  parameter int unsigned POS_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [POS_W-1:0] pos_o,
  input logic [POS_W-1:0] diff_o,
  input logic             err_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R1
      reset_state_chk: assert (pos_o == '0 && diff_o == '0 && !err_o);
    end
  end

  // R3
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pos_o) < int'(RING_LEN));

  // R4
  diff_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(diff_o) < int'(RING_LEN));

  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> pos_o == $past(pos_o));

  // R6
  err_diff_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> diff_o == '0);

  // R4
  diff_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && $past(rst_ni)) |->
      int'(diff_o) == ((int'(pos_o) + int'(RING_LEN) - int'($past(pos_o))) % int'(RING_LEN)));
endmodule

bind ring_phase_decoder ring_phase_decoder_chk #(
  .RING_LEN(RING_LEN),
  .POS_W   (POS_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .pos_o (pos_o),
  .diff_o(diff_o),
  .err_o (err_o)
);

// File: tb/ring_phase_decoder_test.sv
module ring_phase_decoder_test;
  localparam int N = 15;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] nodes = '0;
  logic [W-1:0] pos, diff;
  logic         err;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string req    = "R1";

  // reference state
  logic [N-1:0] m_samp;
  bit           m_vld;
  int           m_pos, m_diff;
  bit           m_err;

  always #10 clk = ~clk;

  ring_phase_decoder uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .nodes_i(nodes),
    .pos_o  (pos),
    .diff_o (diff),
    .err_o  (err)
  );

  function automatic logic [N-1:0] ring_at(int p, bit b);
    logic [N-1:0] v;
    for (int j = 0; j < N; j++) v[(p + 1 + j) % N] = b ^ bit'(j & 1);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_samp = '0; m_vld = 0; m_pos = 0; m_diff = 0; m_err = 0;
    end else begin
      if (m_vld) begin
        int hits, first;
        hits = 0; first = -1;
        for (int i = 0; i < N; i++)
          if (m_samp[i] == m_samp[(i + 1) % N]) begin
            hits++;
            if (first < 0) first = i;
          end
        if (hits == 1) begin
          m_diff = (first - m_pos + N) % N;
          m_pos  = first;
          m_err  = 0;
        end else begin
          m_diff = 0;
          m_err  = 1;
        end
      end
      m_samp = nodes;
      m_vld  = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(pos) != m_pos) begin
        fails++;
        $display("FAIL %s pos_o: got %0d expected %0d", req, pos, m_pos);
      end
      checks++;
      if (int'(diff) != m_diff) begin
        fails++;
        $display("FAIL %s diff_o: got %0d expected %0d", req, diff, m_diff);
      end
      checks++;
      if (err != m_err) begin
        fails++;
        $display("FAIL %s err_o: got %0d expected %0d", req, err, m_err);
      end
    end
  end

  task automatic put(input logic [N-1:0] v);
    @(negedge clk);
    #2 nodes = v;
  endtask

  task automatic put_pos(input int p, input bit b);
    put(ring_at(p, b));
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [N-1:0] triple;
    nodes = ring_at(4, 1'b0);
    repeat (4) @(negedge clk);          // R1 checked under reset
    #2 rst_n = 1'b1;

    req = "R2 R3";                      // latency and position decode
    put_pos(5, 1'b0); put_pos(11, 1'b1); put_pos(0, 1'b0); put_pos(7, 1'b1);
    put_pos(7, 1'b1);

    req = "R8";                         // single steps through the wrap
    for (int k = 8; k < 8 + N + 3; k++) put_pos(k % N, bit'(k & 1));

    req = "R5";                         // backward steps borrow
    put_pos(13, 1'b0); put_pos(2, 1'b1); put_pos(1, 1'b0); put_pos(0, 1'b1);
    put_pos(14, 1'b0);

    req = "R4";                         // forward jumps and a hold
    put_pos(3, 1'b1); put_pos(10, 1'b0); put_pos(10, 1'b0); put_pos(14, 1'b1);

    req = "R6";                         // multiple agreeing pairs
    put_pos(6, 1'b0);
    put('0);
    triple = '0;
    for (int j = 3; j < N; j++) triple[j] = bit'((j - 3) & 1) ^ 1'b1;
    put(triple);
    put({N{1'b1}});

    req = "R7";                         // recovery from held position
    put_pos(2, 1'b1); put_pos(9, 1'b0); put('0); put_pos(4, 1'b1);

    repeat (3) @(negedge clk);
    #1 finish_run();
  end

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule